// File: doc/BRIEF.md
# Tagged-Opcode Logic and Compare Unit

This block evaluates one operation per cycle on two 64-bit unsigned operands. A 4-bit tag picks the operation: equality, unsigned less-than, bitwise XOR, AND and NOT, a left shift, or a two-way select steered by a separate 64-bit test word. The two predicates return a 64-bit word in which zero stands for "true" and one for "false". The select follows the same rule and takes its first arm when the test word is zero. Field arithmetic is handled by other blocks, so any tag this unit does not implement raises a flag and produces a zero result.

The combinational datapath sits behind one register stage. An operation presented with `valid_in` high appears on `result` and `unsupported` one clock later, with `valid_out` high. While `valid_in` is low the outputs keep their last captured values. A new operation can be accepted on every cycle.

Top module: `tagop_unit`

## Requirements
- R1: Tag 9 (equality) yields 0 when `opnd_a` equals `opnd_b` and 1 otherwise, with bits 63..1 always zero.
- R2: Tag 10 (unsigned less-than) yields 0 when `opnd_a` < `opnd_b` as unsigned numbers and 1 when `opnd_a` >= `opnd_b`.
- R3: Tag 11 yields `opnd_a` XOR `opnd_b`, and tag 12 yields `opnd_a` AND `opnd_b`.
- R4: Tag 13 yields the bitwise complement of `opnd_a`, and `opnd_b` has no effect on it.
- R5: Tag 14 shifts `opnd_a` left by `opnd_b[5:0]` (0 to 63 places) and fills with zeros from the right. Bits 63..6 of `opnd_b` have no effect.
- R6: Tag 4 (select) yields `opnd_a` when `test_word` is zero and `opnd_b` for any nonzero `test_word`.
- R7: Tags 0-3, 5-8 and 15 set `unsupported` to 1 and `result` to zero. Tags 4 and 9-14 leave `unsupported` at 0.
- R8: `valid_out` is `valid_in` delayed by exactly one clock, and the result of each accepted operation appears in the cycle in which `valid_out` is high.
- R9: While `rst_n` is low (active-low, asynchronous), `valid_out`, `result` and `unsupported` are all zero.
- R10: In a cycle after `valid_in` was low, `result` and `unsupported` keep their previous values whatever the tag and operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operation present this cycle |
| op_tag | input | 4 | Operation tag |
| opnd_a | input | 64 | First operand, also the first select arm |
| opnd_b | input | 64 | Second operand, shift amount source, second select arm |
| test_word | input | 64 | Select steering word; zero picks the first arm |
| valid_out | output | 1 | Result registered from an accepted operation |
| result | output | 64 | Registered operation result |
| unsupported | output | 1 | Registered flag for an unimplemented tag |

## Verification
In one cycle the register stage can present a finished result while capturing the next operation, and the scoreboard must keep the two apart. The bench provokes this by issuing operations back to back, including runs that mix implemented and unimplemented tags, and judges each output cycle against the queued expectation together with the cycle stamp taken at issue. The bench also provokes the opposite case: while idle, it sends tags and operands that would change the outputs if they were captured, and judges that the held result and flag stay unchanged.

// File: rtl/olu_pkg.sv
package olu_pkg;

    // Operation tags; numeric values are fixed by the instruction encoding
    typedef enum logic [3:0] {
        TAG_PICK = 4'd4,
        TAG_SAME = 4'd9,
        TAG_BELOW = 4'd10,
        TAG_XOR = 4'd11,
        TAG_AND = 4'd12,
        TAG_INV = 4'd13,
        TAG_SHL = 4'd14
    } olu_tag_e;

    // Inverted truth convention for predicate words
    localparam logic PRED_TRUE = 1'b0;
    localparam logic PRED_FALSE = 1'b1;

endpackage

// File: rtl/olu_compare.sv
module olu_compare #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] same_res,
    output logic [W-1:0] below_res
);
    import olu_pkg::*;

    logic same_bit;
    logic below_bit;

    always_comb begin
        same_bit = (a == b) ? PRED_TRUE : PRED_FALSE;
        below_bit = (a < b) ? PRED_TRUE : PRED_FALSE;
        same_res = {{(W-1){1'b0}}, same_bit};
        below_res = {{(W-1){1'b0}}, below_bit};
    end

endmodule

// File: rtl/olu_bitwise.sv
module olu_bitwise #(
    parameter int W = 64,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] xor_res,
    output logic [W-1:0] and_res,
    output logic [W-1:0] inv_res,
    output logic [W-1:0] shl_res
);

    logic [SHW-1:0] shamt;

    // One lane per bit for the purely bitwise operations
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign xor_res[i] = a[i] ^ b[i];
        assign and_res[i] = a[i] & b[i];
        assign inv_res[i] = ~a[i];
    end

    always_comb begin
        shamt = b[SHW-1:0];
        shl_res = a << shamt;
    end

endmodule

// File: rtl/olu_select.sv
module olu_select #(
    parameter int W = 64
) (
    input  logic [W-1:0] test,
    input  logic [W-1:0] arm_zero,
    input  logic [W-1:0] arm_nonzero,
    output logic [W-1:0] pick_res
);

    always_comb begin
        pick_res = (test == '0) ? arm_zero : arm_nonzero;
    end

endmodule

// File: rtl/olu_core.sv
module olu_core #(
    parameter int W = 64
) (
    input  logic [3:0]   tag,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] test,
    output logic [W-1:0] res,
    output logic         unsup
);
    import olu_pkg::*;

    logic [W-1:0] same_res;
    logic [W-1:0] below_res;
    logic [W-1:0] xor_res;
    logic [W-1:0] and_res;
    logic [W-1:0] inv_res;
    logic [W-1:0] shl_res;
    logic [W-1:0] pick_res;

    olu_compare #(.W(W)) u_cmp (
        .a        (a),
        .b        (b),
        .same_res (same_res),
        .below_res(below_res)
    );

    olu_bitwise #(.W(W)) u_bit (
        .a      (a),
        .b      (b),
        .xor_res(xor_res),
        .and_res(and_res),
        .inv_res(inv_res),
        .shl_res(shl_res)
    );

    olu_select #(.W(W)) u_sel (
        .test       (test),
        .arm_zero   (a),
        .arm_nonzero(b),
        .pick_res   (pick_res)
    );

    always_comb begin
        res = '0;
        unsup = 1'b0;
        case (tag)
            TAG_PICK:  res = pick_res;
            TAG_SAME:  res = same_res;
            TAG_BELOW: res = below_res;
            TAG_XOR:   res = xor_res;
            TAG_AND:   res = and_res;
            TAG_INV:   res = inv_res;
            TAG_SHL:   res = shl_res;
            default:   unsup = 1'b1;
        endcase
    end

endmodule

// File: rtl/tagop_unit.sv
module tagop_unit #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic [3:0]   op_tag,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] test_word,
    output logic         valid_out,
    output logic [W-1:0] result,
    output logic         unsupported
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         uns;
    } stage_t;

    logic [W-1:0] core_res;
    logic         core_uns;
    stage_t       stage_d;
    stage_t       stage_q;

    olu_core #(.W(W)) u_core (
        .tag  (op_tag),
        .a    (opnd_a),
        .b    (opnd_b),
        .test (test_word),
        .res  (core_res),
        .unsup(core_uns)
    );

    always_comb begin
        stage_d = stage_q;
        stage_d.vld = valid_in;
        if (valid_in) begin
            stage_d.res = core_res;
            stage_d.uns = core_uns;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign valid_out = stage_q.vld;
    assign result = stage_q.res;
    assign unsupported = stage_q.uns;

    // Marks that one clock has passed since reset, so $past is meaningful
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (valid_out == $past(valid_in)));

    a_r7_zero_on_unsup: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (result == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(valid_in)) |-> ($stable(result) && $stable(unsupported)));

    a_r6_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(valid_in) && $past(op_tag) == 4'd4) |->
        (result == (($past(test_word) == '0) ? $past(opnd_a) : $past(opnd_b))));

    a_r1_same: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(valid_in) && $past(op_tag) == 4'd9) |->
        (result == {{(W-1){1'b0}}, ($past(opnd_a) != $past(opnd_b))}));

endmodule

// File: tb/tb_tagop_unit.sv
`timescale 1ns/1ps
module tb_tagop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [3:0]  op_tag = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] test_word = '0;
    logic        valid_out;
    logic [63:0] result;
    logic        unsupported;

    tagop_unit #(.W(64)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .op_tag     (op_tag),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .test_word  (test_word),
        .valid_out  (valid_out),
        .result     (result),
        .unsupported(unsupported)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [63:0] res;
        logic        uns;
        string       req;
        int          cyc;
    } exp_t;

    exp_t        sb[$];
    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    bit          have_last = 0;
    logic [63:0] last_res;
    logic        last_uns;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(logic [3:0] tag, logic [63:0] a, logic [63:0] b, logic [63:0] t);
        exp_t e;
        e.uns = 1'b0;
        e.cyc = 0;
        case (tag)
            4'd9:  begin e.res = (a == b) ? 64'd0 : 64'd1; e.req = "R1"; end
            4'd10: begin e.res = (a < b) ? 64'd0 : 64'd1; e.req = "R2"; end
            4'd11: begin e.res = a ^ b; e.req = "R3"; end
            4'd12: begin e.res = a & b; e.req = "R3"; end
            4'd13: begin e.res = ~a; e.req = "R4"; end
            4'd14: begin e.res = a << b[5:0]; e.req = "R5"; end
            4'd4:  begin e.res = (t == 64'd0) ? a : b; e.req = "R6"; end
            default: begin e.res = 64'd0; e.uns = 1'b1; e.req = "R7"; end
        endcase
        return e;
    endfunction

    task automatic issue(logic [3:0] tag, logic [63:0] a, logic [63:0] b, logic [63:0] t);
        exp_t e;
        @(negedge clk);
        op_tag = tag;
        opnd_a = a;
        opnd_b = b;
        test_word = t;
        valid_in = 1'b1;
        e = model(tag, a, b, t);
        e.cyc = cyc;
        sb.push_back(e);
    endtask

    // Idle cycles with scrambled inputs that must not be captured (R10)
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            op_tag = 4'($urandom);
            opnd_a = {$urandom, $urandom};
            opnd_b = {$urandom, $urandom};
            test_word = {$urandom, $urandom};
        end
    endtask

    // Monitor: pops the scoreboard when a result is presented
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_out) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "unexpected valid_out", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res, e.req, "result", result, e.res);
                    check(unsupported == e.uns, (e.uns ? "R7" : e.req), "unsupported flag",
                          64'(unsupported), 64'(e.uns));
                    check(cyc - e.cyc == 1, "R8", "latency", 64'(cyc - e.cyc), 64'd1);
                    last_res = e.res;
                    last_uns = e.uns;
                    have_last = 1;
                end
            end else if (have_last) begin
                check(result == last_res, "R10", "held result", result, last_res);
                check(unsupported == last_uns, "R10", "held flag", 64'(unsupported), 64'(last_uns));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000 - 1000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] legal [7];
        legal = '{4'd4, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14};
        // R9: reset state with busy inputs
        opnd_a = 64'hFFFF_0000_1234_5678;
        opnd_b = 64'h1;
        op_tag = 4'd13;
        repeat (3) @(negedge clk);
        check(valid_out == 1'b0, "R9", "valid_out in reset", 64'(valid_out), 64'd0);
        check(result == 64'd0, "R9", "result in reset", result, 64'd0);
        check(unsupported == 1'b0, "R9", "flag in reset", 64'(unsupported), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check(valid_out == 1'b0, "R9", "valid_out after reset", 64'(valid_out), 64'd0);

        // R1 equality
        issue(4'd9, 64'h55, 64'h55, 0);
        issue(4'd9, 64'h55, 64'h54, 0);
        issue(4'd9, 64'h8000_0000_0000_0000, 64'h0, 0);
        // R2 unsigned less-than
        issue(4'd10, 64'd3, 64'd5, 0);
        issue(4'd10, 64'd5, 64'd3, 0);
        issue(4'd10, 64'd7, 64'd7, 0);
        issue(4'd10, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        issue(4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0);
        idle(2);
        // R3 xor / and
        issue(4'd11, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFFFF_0000_FFFF_0000, 0);
        issue(4'd12, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFFFF_0000_FFFF_0000, 0);
        // R4 not, b must not matter
        issue(4'd13, 64'h0123_4567_89AB_CDEF, 64'd0, 0);
        issue(4'd13, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        // R5 shift boundaries
        issue(4'd14, 64'hDEAD_BEEF_0000_0001, 64'd0, 0);
        issue(4'd14, 64'h3, 64'd63, 0);
        issue(4'd14, 64'h3, 64'd65, 0);
        issue(4'd14, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFE0, 0);
        idle(3);
        // R6 select
        issue(4'd4, 64'hAAAA, 64'hBBBB, 64'd0);
        issue(4'd4, 64'hAAAA, 64'hBBBB, 64'h8000_0000_0000_0000);
        issue(4'd4, 64'hAAAA, 64'hBBBB, 64'd1);
        // R7 every tag, back to back
        for (int tg = 0; tg < 16; tg++) begin
            issue(4'(tg), {$urandom, $urandom}, {$urandom, $urandom}, 64'(tg & 1));
        end
        idle(4);
        // Random mix of legal and illegal tags with idle gaps (R8, R10)
        for (int n = 0; n < 300; n++) begin
            logic [3:0] tg;
            tg = ($urandom % 4 == 0) ? 4'($urandom) : legal[$urandom % 7];
            issue(tg, {$urandom, $urandom}, ($urandom % 8 == 0) ? 64'd0 : {$urandom, $urandom},
                  ($urandom % 3 == 0) ? 64'd0 : {$urandom, $urandom});
            if ($urandom % 5 == 0) idle(1 + $urandom % 3);
        end
        idle(4);
        check(sb.size() == 0, "R8", "scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule